// File: doc/BRIEF.md
# Transceiver Power Mode Controller

This block is the digital mode manager for a bus transceiver that carries its own supply regulator. It picks one of five operating modes: unpowered, fail-safe, normal, silent and sleep. It drives the enables of the regulator, the transmit path, the receive path and the slave termination. It also drives the active-low reset output for the attached microcontroller and a flag that holds the receive pin low to signal a wake-up. All analog conditions reach it as digital flags: the two supply comparators, VCC undervoltage, a bus wake-up detector, the pre-wake bus detector and a read-back of the reset line. The enable and transmit-data pins also arrive as flags. Each flag passes through a two-flop synchronizer.

Timing is counted in ticks of a 1 MHz tick-enable input. The reset pulse lasts `RST_TICKS` ticks (4000 by default, which is 4 ms), counted from the moment VCC is good. No mode change is accepted while the pulse runs. When the enable pin falls in normal mode, the transmitter turns off at once. The controller then waits a select window of `SEL_TICKS` ticks (3 by default) and uses the transmit-data level at the end of that window to choose silent or sleep.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: During and just after synchronous reset, every output is low. This means regulator off, reset output asserted (low), no transmit, no receive, no termination and no wake flag.
- R2: In unpowered mode, a supply-above-threshold flag moves the block to fail-safe. In fail-safe the regulator enable is 1, transmit and receive enables are 0 and the termination enable is 1.
- R3: On entry to fail-safe from unpowered, from sleep, or after an undervoltage or reset-line fault, the reset output stays low until VCC has been good for `RST_TICKS` ticks. During this time an enable pin held high does not start normal mode.
- R4: In fail-safe with no reset pulse running, enable high moves to normal mode: transmit enable 1, receive enable 1, regulator enable 1, reset output high.
- R5: In normal mode, enable low turns the transmit enable off within 4 clock cycles. If transmit data is 1 at the end of the select window, the block enters silent mode: regulator enable 1, transmit and receive enables 0, reset output high.
- R6: If transmit data is 0 at the end of the select window, the block enters sleep mode: regulator enable 0, reset output low, wake flag (RXD held low) 1.
- R7: Transmit data is sampled when the select window of `SEL_TICKS` ticks ends, not at the enable edge. The mode change completes within 20 ticks of the enable falling.
- R8: VCC undervoltage in normal or silent mode forces fail-safe with the reset output low and transmit off. The reset pulse does not count while undervoltage persists.
- R9: The reset line read back low while the block drives it high, in normal or silent mode, forces fail-safe with a full reset pulse.
- R10: A bus wake-up in silent mode moves to fail-safe with the wake flag 1 and no reset pulse. A wake-up and enable high in the same cycle resolve as wake first, then normal. Entering normal clears the wake flag.
- R11: A bus wake-up in sleep mode turns the regulator on and sets the wake flag, with a full reset pulse. Normal mode follows if enable is high when the pulse ends.
- R12: Enable high in sleep mode moves to fail-safe with a reset pulse, then to normal once the pulse ends.
- R13: Supply-below-threshold in any mode returns to unpowered, with all outputs low. Enable and bus wake-up are ignored there, and only supply-above-threshold leaves unpowered.
- R14: Termination enable is 1 in fail-safe and normal modes. In silent and sleep modes it follows the pre-wake detector flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 1 MHz tick enable, synchronous to clk |
| vs_above_i | input | 1 | Supply above upper threshold (async) |
| vs_below_i | input | 1 | Supply below lower threshold (async) |
| vcc_uv_i | input | 1 | Regulator output undervoltage (async) |
| en_i | input | 1 | Enable pin level (async) |
| txd_i | input | 1 | Transmit data pin level (async) |
| bus_wake_i | input | 1 | Bus wake-up detected (async level, at least 2 clocks) |
| prewake_i | input | 1 | Pre-wake bus level detected (async) |
| nres_line_i | input | 1 | Read-back of the reset line (async) |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| term_en_o | output | 1 | Slave termination enable |
| nres_o | output | 1 | Reset output, active low |
| rxd_low_o | output | 1 | Hold receive pin low (sleep or wake signal) |

## Verification
Two functions can fall in the same cycle: a bus wake-up and enable going high can both arrive while the block is in silent mode. The bench drives both edges at the same clock edge. It then judges the result from the outputs. Wake-up must win: the block passes through fail-safe with no reset pulse and then reaches normal. The reset output must stay high, transmit must end up enabled and the wake flag must end up cleared. A second test raises transmit data inside the select window and shows that the level at the end of the window chooses between silent and sleep.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

  typedef enum logic [2:0] {
    MD_OFF      = 3'd0,
    MD_FAILSAFE = 3'd1,
    MD_NORMAL   = 3'd2,
    MD_SELECT   = 3'd3,
    MD_SILENT   = 3'd4,
    MD_SLEEP    = 3'd5
  } mode_e;

  // positions of the flags in the synchronizer bank
  localparam int unsigned FLAG_N     = 8;
  localparam int unsigned F_VS_HI    = 0;
  localparam int unsigned F_VS_LO    = 1;
  localparam int unsigned F_UV       = 2;
  localparam int unsigned F_EN       = 3;
  localparam int unsigned F_TXD      = 4;
  localparam int unsigned F_WAKE     = 5;
  localparam int unsigned F_PREWAKE  = 6;
  localparam int unsigned F_LINE     = 7;

  // idle levels of the pins: txd and reset line rest high
  localparam logic [FLAG_N-1:0] FLAG_IDLE = 8'b1001_0000;

endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/xmc_tick_cnt.sv
module xmc_tick_cnt #(
  parameter int unsigned LIMIT = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i & tick_i & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (tick_i)   cnt <= done_o ? '0 : cnt + CW'(1);
  end

endmodule

// File: rtl/xmc_fsm.sv
module xmc_fsm
  import xmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vs_hi,
  input  logic vs_lo,
  input  logic uv,
  input  logic en,
  input  logic txd,
  input  logic wake,
  input  logic prewake,
  input  logic line,
  input  logic rst_done,
  input  logic sel_done,
  output logic rst_run,
  output logic sel_run,
  output logic reg_en_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic term_en_o,
  output logic nres_o,
  output logic rxd_low_o
);

  mode_e st, nx;
  logic  busy, nbusy;
  logic  wake_f, nwake;
  logic [1:0] nres_hist;
  logic  ext_low, fault;

  logic reg_d, tx_d, rx_d, term_d, nres_d, rxdl_d;

  assign rst_run = (st == MD_FAILSAFE) & busy & ~uv;
  assign sel_run = (st == MD_SELECT);

  // the line only counts as an outside fault once our own high has settled
  assign ext_low = ~line & nres_o & nres_hist[0] & nres_hist[1];
  assign fault   = uv | ext_low;

  always_comb begin
    nx    = st;
    nbusy = busy;
    nwake = wake_f;
    if (vs_lo) begin
      nx    = MD_OFF;
      nbusy = 1'b0;
      nwake = 1'b0;
    end else begin
      case (st)
        MD_OFF: begin
          if (vs_hi) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
            nwake = 1'b0;
          end
        end
        MD_FAILSAFE: begin
          if (uv)          nbusy = 1'b1;
          else if (busy) begin
            if (rst_done)  nbusy = 1'b0;
          end else if (en) begin
            nx    = MD_NORMAL;
            nwake = 1'b0;
          end
        end
        MD_NORMAL: begin
          if (fault) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
          end else if (!en) begin
            nx = MD_SELECT;
          end
        end
        MD_SELECT: begin
          if (fault) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
          end else if (sel_done) begin
            nx = txd ? MD_SILENT : MD_SLEEP;
          end
        end
        MD_SILENT: begin
          if (fault) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
          end else if (wake) begin
            nx    = MD_FAILSAFE;
            nwake = 1'b1;
          end else if (en) begin
            nx = MD_NORMAL;
          end
        end
        MD_SLEEP: begin
          if (wake) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
            nwake = 1'b1;
          end else if (en) begin
            nx    = MD_FAILSAFE;
            nbusy = 1'b1;
          end
        end
        default: begin
          nx    = MD_OFF;
          nbusy = 1'b0;
          nwake = 1'b0;
        end
      endcase
    end
  end

  // output decode from the next mode so the registered pins line up with it
  always_comb begin
    reg_d  = (nx == MD_FAILSAFE) | (nx == MD_NORMAL) |
             (nx == MD_SELECT)   | (nx == MD_SILENT);
    tx_d   = (nx == MD_NORMAL);
    rx_d   = (nx == MD_NORMAL);
    term_d = (nx == MD_FAILSAFE) | (nx == MD_NORMAL) | (nx == MD_SELECT) |
             (((nx == MD_SILENT) | (nx == MD_SLEEP)) & prewake);
    nres_d = reg_d & ~nbusy;
    rxdl_d = (nx == MD_SLEEP) | ((nx == MD_FAILSAFE) & nwake);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MD_OFF;
      busy      <= 1'b0;
      wake_f    <= 1'b0;
      nres_hist <= '0;
      reg_en_o  <= 1'b0;
      tx_en_o   <= 1'b0;
      rx_en_o   <= 1'b0;
      term_en_o <= 1'b0;
      nres_o    <= 1'b0;
      rxd_low_o <= 1'b0;
    end else begin
      st        <= nx;
      busy      <= nbusy;
      wake_f    <= nwake;
      nres_hist <= {nres_hist[0], nres_o};
      reg_en_o  <= reg_d;
      tx_en_o   <= tx_d;
      rx_en_o   <= rx_d;
      term_en_o <= term_d;
      nres_o    <= nres_d;
      rxd_low_o <= rxdl_d;
    end
  end

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int unsigned RST_TICKS   = 4000,
  parameter int unsigned SEL_TICKS   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic vs_above_i,
  input  logic vs_below_i,
  input  logic vcc_uv_i,
  input  logic en_i,
  input  logic txd_i,
  input  logic bus_wake_i,
  input  logic prewake_i,
  input  logic nres_line_i,
  output logic reg_en_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic term_en_o,
  output logic nres_o,
  output logic rxd_low_o
);

  logic [FLAG_N-1:0] raw, flg;
  logic rst_run, sel_run, rst_done, sel_done;

  assign raw = {nres_line_i, prewake_i, bus_wake_i, txd_i,
                en_i, vcc_uv_i, vs_below_i, vs_above_i};

  xmc_sync #(
    .WIDTH  (FLAG_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(FLAG_IDLE)
  ) sync_i (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(flg)
  );

  xmc_tick_cnt #(.LIMIT(RST_TICKS)) rst_cnt_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(rst_run), .done_o(rst_done)
  );

  xmc_tick_cnt #(.LIMIT(SEL_TICKS)) sel_cnt_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(sel_run), .done_o(sel_done)
  );

  xmc_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .vs_hi    (flg[F_VS_HI]),
    .vs_lo    (flg[F_VS_LO]),
    .uv       (flg[F_UV]),
    .en       (flg[F_EN]),
    .txd      (flg[F_TXD]),
    .wake     (flg[F_WAKE]),
    .prewake  (flg[F_PREWAKE]),
    .line     (flg[F_LINE]),
    .rst_done (rst_done),
    .sel_done (sel_done),
    .rst_run  (rst_run),
    .sel_run  (sel_run),
    .reg_en_o (reg_en_o),
    .tx_en_o  (tx_en_o),
    .rx_en_o  (rx_en_o),
    .term_en_o(term_en_o),
    .nres_o   (nres_o),
    .rxd_low_o(rxd_low_o)
  );

endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic vs_below_i,
  input logic reg_en_o,
  input logic tx_en_o,
  input logic term_en_o,
  input logic nres_o,
  input logic rxd_low_o
);

  // R4: transmitting needs the regulator up and reset released
  a_r4_tx_needs_power: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> (reg_en_o && nres_o));

  // R3: the cycle reset releases is never already a normal-mode cycle
  a_r3_release_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(nres_o) |-> !tx_en_o);

  // R5: transmit only while the enable pin was high three edges back
  a_r5_tx_follows_en: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> $past(en_i, 3));

  // R10: a wake signal or sleep never coexists with transmission
  a_r10_wake_no_tx: assert property (@(posedge clk) disable iff (rst)
    rxd_low_o |-> !tx_en_o);

  // R13: regulator on only if the supply was not low three edges back
  a_r13_supply_gate: assert property (@(posedge clk) disable iff (rst)
    reg_en_o |-> !$past(vs_below_i, 3));

  // R14: normal mode always has termination
  a_r14_term_in_normal: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> term_en_o);

endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .en_i      (en_i),
  .vs_below_i(vs_below_i),
  .reg_en_o  (reg_en_o),
  .tx_en_o   (tx_en_o),
  .term_en_o (term_en_o),
  .nres_o    (nres_o),
  .rxd_low_o (rxd_low_o)
);

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RST_T      = 4000;
  localparam int PULSE_CYC  = 2 * RST_T;   // one tick every two clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic vs_above_i = 1'b0, vs_below_i = 1'b0, vcc_uv_i = 1'b0;
  logic en_i = 1'b0, txd_i = 1'b1, bus_wake_i = 1'b0;
  logic prewake_i = 1'b0, nres_line_i = 1'b1;
  logic reg_en_o, tx_en_o, rx_en_o, term_en_o, nres_o, rxd_low_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_i = ~tick_i;
  end

  xcvr_mode_ctrl #(.RST_TICKS(RST_T), .SEL_TICKS(3)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .vs_above_i(vs_above_i), .vs_below_i(vs_below_i), .vcc_uv_i(vcc_uv_i),
    .en_i(en_i), .txd_i(txd_i), .bus_wake_i(bus_wake_i),
    .prewake_i(prewake_i), .nres_line_i(nres_line_i),
    .reg_en_o(reg_en_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
    .term_en_o(term_en_o), .nres_o(nres_o), .rxd_low_o(rxd_low_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset_state;
    step(4);
    rst = 1'b0;
    step(2);
    chk("R1", "reg_en", reg_en_o, 1'b0);
    chk("R1", "nres", nres_o, 1'b0);
    chk("R1", "tx_en", tx_en_o, 1'b0);
    chk("R1", "rx_en", rx_en_o, 1'b0);
    chk("R1", "term_en", term_en_o, 1'b0);
    chk("R1", "rxd_low", rxd_low_o, 1'b0);
  endtask

  task automatic t_power_up;
    en_i = 1'b1;
    vs_above_i = 1'b1;
    step(10);
    chk("R2", "reg_en", reg_en_o, 1'b1);
    chk("R2", "tx_en", tx_en_o, 1'b0);
    chk("R14", "term_en failsafe", term_en_o, 1'b1);
    step(PULSE_CYC - 50);
    chk("R3", "nres late in pulse", nres_o, 1'b0);
    chk("R3", "tx_en blocked", tx_en_o, 1'b0);
    step(80);
    chk("R3", "nres released", nres_o, 1'b1);
    chk("R4", "tx_en normal", tx_en_o, 1'b1);
    chk("R4", "rx_en normal", rx_en_o, 1'b1);
  endtask

  task automatic t_enter_silent;
    txd_i = 1'b1;
    en_i = 1'b0;
    step(4);
    chk("R5", "tx_en drops fast", tx_en_o, 1'b0);
    step(36);
    chk("R5", "reg_en silent", reg_en_o, 1'b1);
    chk("R5", "rx_en silent", rx_en_o, 1'b0);
    chk("R5", "nres silent", nres_o, 1'b1);
    chk("R14", "term_en silent idle", term_en_o, 1'b0);
    prewake_i = 1'b1;
    step(5);
    chk("R14", "term_en prewake", term_en_o, 1'b1);
    prewake_i = 1'b0;
    step(5);
  endtask

  task automatic t_wake_silent;
    bus_wake_i = 1'b1;
    step(5);
    bus_wake_i = 1'b0;
    step(5);
    chk("R10", "rxd_low after wake", rxd_low_o, 1'b1);
    chk("R10", "nres no pulse", nres_o, 1'b1);
    chk("R10", "term_en failsafe", term_en_o, 1'b1);
    en_i = 1'b1;
    step(6);
    chk("R10", "tx_en normal", tx_en_o, 1'b1);
    chk("R10", "rxd_low cleared", rxd_low_o, 1'b0);
  endtask

  task automatic t_same_cycle;
    en_i = 1'b0;
    step(40);
    bus_wake_i = 1'b1;
    en_i = 1'b1;
    step(5);
    bus_wake_i = 1'b0;
    step(5);
    chk("R10", "same-cycle tx_en", tx_en_o, 1'b1);
    chk("R10", "same-cycle nres", nres_o, 1'b1);
    chk("R10", "same-cycle rxd_low", rxd_low_o, 1'b0);
  endtask

  task automatic t_enter_sleep;
    txd_i = 1'b0;
    en_i = 1'b0;
    step(40);
    chk("R6", "reg_en sleep", reg_en_o, 1'b0);
    chk("R6", "nres sleep", nres_o, 1'b0);
    chk("R6", "rxd_low sleep", rxd_low_o, 1'b1);
    txd_i = 1'b1;
    step(4);
  endtask

  task automatic t_wake_sleep;
    bus_wake_i = 1'b1;
    step(5);
    bus_wake_i = 1'b0;
    en_i = 1'b1;
    step(3);
    chk("R11", "reg_en on", reg_en_o, 1'b1);
    chk("R11", "rxd_low wake", rxd_low_o, 1'b1);
    chk("R11", "nres pulse", nres_o, 1'b0);
    step(PULSE_CYC + 60);
    chk("R11", "tx_en normal", tx_en_o, 1'b1);
    chk("R11", "rxd_low cleared", rxd_low_o, 1'b0);
  endtask

  task automatic t_en_sleep;
    txd_i = 1'b0;
    en_i = 1'b0;
    step(40);
    chk("R12", "reg_en sleep", reg_en_o, 1'b0);
    txd_i = 1'b1;
    en_i = 1'b1;
    step(6);
    chk("R12", "reg_en on", reg_en_o, 1'b1);
    chk("R12", "nres pulse", nres_o, 1'b0);
    chk("R12", "tx_en blocked", tx_en_o, 1'b0);
    step(PULSE_CYC + 60);
    chk("R12", "tx_en normal", tx_en_o, 1'b1);
  endtask

  task automatic t_window;
    txd_i = 1'b0;
    en_i = 1'b0;
    step(3);
    txd_i = 1'b1;
    step(37);
    chk("R7", "late txd picks silent reg_en", reg_en_o, 1'b1);
    chk("R7", "late txd picks silent nres", nres_o, 1'b1);
    chk("R7", "late txd no sleep flag", rxd_low_o, 1'b0);
    en_i = 1'b1;
    step(6);
    chk("R7", "back to normal", tx_en_o, 1'b1);
  endtask

  task automatic t_undervolt;
    vcc_uv_i = 1'b1;
    step(6);
    chk("R8", "nres low", nres_o, 1'b0);
    chk("R8", "tx_en off", tx_en_o, 1'b0);
    chk("R8", "reg_en on", reg_en_o, 1'b1);
    step(PULSE_CYC + 200);
    chk("R8", "pulse held during uv", nres_o, 1'b0);
    vcc_uv_i = 1'b0;
    step(PULSE_CYC - 40);
    chk("R8", "pulse restarted", nres_o, 1'b0);
    step(100);
    chk("R8", "nres released", nres_o, 1'b1);
    chk("R8", "tx_en normal", tx_en_o, 1'b1);
  endtask

  task automatic t_line_low;
    nres_line_i = 1'b0;
    step(6);
    nres_line_i = 1'b1;
    chk("R9", "tx_en off", tx_en_o, 1'b0);
    chk("R9", "nres low", nres_o, 1'b0);
    step(PULSE_CYC + 60);
    chk("R9", "nres released", nres_o, 1'b1);
    chk("R9", "tx_en normal", tx_en_o, 1'b1);
  endtask

  task automatic t_supply_loss;
    vs_below_i = 1'b1;
    vs_above_i = 1'b0;
    step(6);
    chk("R13", "reg_en off", reg_en_o, 1'b0);
    chk("R13", "tx_en off", tx_en_o, 1'b0);
    chk("R13", "term_en off", term_en_o, 1'b0);
    chk("R13", "rxd_low off", rxd_low_o, 1'b0);
    bus_wake_i = 1'b1;
    step(5);
    bus_wake_i = 1'b0;
    vs_below_i = 1'b0;
    step(10);
    chk("R13", "wake and en ignored", reg_en_o, 1'b0);
    vs_above_i = 1'b1;
    step(6);
    chk("R13", "supply back reg_en", reg_en_o, 1'b1);
    chk("R13", "supply back nres", nres_o, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_power_up();
    t_enter_silent();
    t_wake_silent();
    t_same_cycle();
    t_enter_sleep();
    t_wake_sleep();
    t_en_sleep();
    t_window();
    t_undervolt();
    t_line_low();
    t_supply_loss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule